// File: doc/BRIEF.md
# Binary-Field Multiply-Add and Carry-Less Product Unit

This unit computes products over binary polynomial arithmetic. Software first loads a modulus polynomial into the unit's configuration register. The field degree m is the index of the highest set bit of that polynomial. After that, each accepted request names one of five operations and gives three operands a, b and c. The five operations are: the field product of a and c; the fused product-plus-addend, which XORs b onto that product; and the low, high or bit-reversed half of the full carry-less product of a and c.

All five operations run on one shift-and-XOR datapath. The datapath consumes one bit of the multiplier c per clock and stops as soon as no set multiplier bit remains. A request is presented with `start` while the unit is idle. `busy` stays high while the request runs. `done` pulses for one clock, and the registered `result` is valid in that clock. A configuration write that arrives while a request is in flight is held back until that request finishes, so each request uses the modulus that was in effect when it was accepted.

Top module: `gf2m_clmul_unit`

## Requirements
- R1: After synchronous reset, `busy`, `done` and `result` are all zero. The modulus register then holds the parameter default (0x11B).
- R2: Op code 0 (field product) returns the shift-and-reduce product of a and c. On each multiplier step, a set multiplier LSB XORs the multiplicand into the accumulator. The multiplicand then shifts left, and if its bit m is set it is XORed with the modulus. The final result keeps only bits m-1..0, where m is the index of the highest set bit of the modulus. Two examples: 0b111·0b101 = 0b110 under 0b1011, and 0x80·0x83 = 0x01 under 0x11B.
- R3: Op code 1 (fused) returns the op-0 result of a and c XORed with b.
- R4: Op code 2 returns bits 63..0 of the 128-bit carry-less product of a and c.
- R5: Op code 3 returns bits 127..64 of that carry-less product.
- R6: Op code 4 returns bits 126..63 of that carry-less product.
- R7: Op codes 5, 6 and 7 complete normally with a result of zero.
- R8: `done` is a single-clock pulse. It arrives n clocks after the accepting edge, where n is 1 when c is zero and otherwise one more than the index of the highest set bit of c. `busy` is high from the accepting edge until `done`.
- R9: A `start` pulse raised while `busy` is high is ignored. The running request completes with its own result, and no second `done` follows.
- R10: A configuration write made while `busy` is high, or in the same clock as an accepted `start`, takes effect only after the running request completes. That request uses the old modulus, and the next request uses the new one.
- R11: With a modulus of 0 or 1 (m = 0), op 0 returns zero and op 1 returns b.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Modulus write strobe |
| cfg_mod | input | 64 | Modulus polynomial to write |
| start | input | 1 | Request valid; accepted only when idle |
| op | input | 3 | Operation select (0..4, 5..7 give zero) |
| opnd_a | input | 64 | Multiplicand |
| opnd_b | input | 64 | Addend for the fused operation |
| opnd_c | input | 64 | Multiplier |
| busy | output | 1 | Request in flight |
| done | output | 1 | One-clock result valid pulse |
| result | output | 64 | Registered result |

## Verification
The assertions assume that `rst` is held high across the first clock edges, so that every register starts known. They also assume that `cfg_we` and `start` are clean single-bit levels that change only between clock edges. The bench drives every input on the falling clock edge and samples outputs on the falling edge. It raises `start` only for one clock at a time, including the deliberate pulse sent while the unit is busy. Configuration writes are placed either between requests or in the middle of a running request, which exercises the deferral path without ever stacking two pending writes.

// File: rtl/gfu_pkg.sv
package gfu_pkg;
  typedef enum logic [2:0] {
    OP_GFMUL  = 3'd0,
    OP_GFMADD = 3'd1,
    OP_CL_LO  = 3'd2,
    OP_CL_HI  = 3'd3,
    OP_CL_REV = 3'd4
  } gfu_op_e;
endpackage

// File: rtl/gfu_degree.sv
module gfu_degree #(
  parameter int W  = 64,
  localparam int DW = $clog2(W)
) (
  input  logic [W-1:0]  mod,
  output logic [DW-1:0] deg,
  output logic [W-1:0]  fmask
);
  // degree = index of the highest set bit of the modulus
  always_comb begin
    deg = '0;
    for (int i = 0; i < W; i++) begin
      if (mod[i]) deg = DW'(i);
    end
  end

  // field mask: the bits below the degree
  always_comb begin
    for (int i = 0; i < W; i++) begin
      fmask[i] = (DW'(i) < deg);
    end
  end
endmodule

// File: rtl/gfu_cfg.sv
module gfu_cfg #(
  parameter int         W       = 64,
  parameter logic [W-1:0] RST_MOD = W'('h11B)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cfg_we,
  input  logic [W-1:0] cfg_data,
  input  logic         hold,
  input  logic         release_i,
  output logic [W-1:0] mod_q
);
  logic         pend_v;
  logic [W-1:0] pend_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      mod_q  <= RST_MOD;
      pend_v <= 1'b0;
      pend_d <= '0;
    end else begin
      if (release_i && pend_v) begin
        mod_q  <= pend_d;
        pend_v <= 1'b0;
      end
      if (cfg_we) begin
        if (hold) begin
          pend_d <= cfg_data;
          pend_v <= 1'b1;
        end else begin
          mod_q <= cfg_data;
        end
      end
    end
  end

  AST_CFG_DEFER: assert property (@(posedge clk) disable iff (rst)
    hold |=> $stable(mod_q)); // R10
endmodule

// File: rtl/gfu_step.sv
module gfu_step #(
  parameter int W  = 64,
  localparam int DW = $clog2(W),
  localparam int AW = 2 * W
) (
  input  logic          gf_mode,
  input  logic [W-1:0]  mod,
  input  logic [DW-1:0] deg,
  input  logic [AW-1:0] mcand,
  input  logic          mplier_lsb,
  input  logic [AW-1:0] acc,
  output logic [AW-1:0] acc_nxt,
  output logic [AW-1:0] mcand_nxt
);
  logic [AW-1:0] sh;

  always_comb begin
    acc_nxt = mplier_lsb ? (acc ^ mcand) : acc;
    sh = mcand << 1;
    if (gf_mode && sh[deg]) sh = sh ^ {{W{1'b0}}, mod};
    mcand_nxt = sh;
  end
endmodule

// File: rtl/gfu_pack.sv
module gfu_pack #(
  parameter int W  = 64,
  localparam int AW = 2 * W
) (
  input  gfu_pkg::gfu_op_e op,
  input  logic [AW-1:0]    acc,
  input  logic [W-1:0]     fmask,
  input  logic [W-1:0]     addend,
  output logic [W-1:0]     res
);
  import gfu_pkg::*;

  always_comb begin
    case (op)
      OP_GFMUL:  res = acc[W-1:0] & fmask;
      OP_GFMADD: res = (acc[W-1:0] & fmask) ^ addend;
      OP_CL_LO:  res = acc[W-1:0];
      OP_CL_HI:  res = acc[AW-1:W];
      OP_CL_REV: res = acc[AW-2:W-1];
      default:   res = '0;
    endcase
  end
endmodule

// File: rtl/gf2m_clmul_unit.sv
module gf2m_clmul_unit #(
  parameter int           W       = 64,
  parameter logic [W-1:0] RST_MOD = W'('h11B),
  localparam int DW = $clog2(W),
  localparam int AW = 2 * W,
  localparam int CW = DW + 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cfg_we,
  input  logic [W-1:0] cfg_mod,
  input  logic         start,
  input  logic [2:0]   op,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  input  logic [W-1:0] opnd_c,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] result
);
  import gfu_pkg::*;

  gfu_op_e       op_q;
  logic [W-1:0]  addend_q;
  logic [AW-1:0] mcand_q;
  logic [W-1:0]  mplier_q;
  logic [AW-1:0] acc_q;
  logic [CW-1:0] busy_cnt;

  logic [W-1:0]  mod_w;
  logic [DW-1:0] deg_w;
  logic [W-1:0]  fmask_w;
  logic [AW-1:0] acc_nxt;
  logic [AW-1:0] mcand_nxt;
  logic [W-1:0]  res_nxt;

  logic start_ok;
  logic finish;
  logic gf_mode;

  assign start_ok = start && !busy;
  assign finish   = busy && (mplier_q[W-1:1] == '0);
  assign gf_mode  = (op_q == OP_GFMUL) || (op_q == OP_GFMADD);

  gfu_cfg #(.W(W), .RST_MOD(RST_MOD)) i_cfg (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_data  (cfg_mod),
    .hold      ((busy && !finish) || start_ok),
    .release_i (finish),
    .mod_q     (mod_w)
  );

  gfu_degree #(.W(W)) i_deg (
    .mod   (mod_w),
    .deg   (deg_w),
    .fmask (fmask_w)
  );

  gfu_step #(.W(W)) i_step (
    .gf_mode    (gf_mode),
    .mod        (mod_w),
    .deg        (deg_w),
    .mcand      (mcand_q),
    .mplier_lsb (mplier_q[0]),
    .acc        (acc_q),
    .acc_nxt    (acc_nxt),
    .mcand_nxt  (mcand_nxt)
  );

  gfu_pack #(.W(W)) i_pack (
    .op     (op_q),
    .acc    (acc_nxt),
    .fmask  (fmask_w),
    .addend (addend_q),
    .res    (res_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      result   <= '0;
      op_q     <= OP_GFMUL;
      addend_q <= '0;
      mcand_q  <= '0;
      mplier_q <= '0;
      acc_q    <= '0;
      busy_cnt <= '0;
    end else begin
      done <= 1'b0;
      if (start_ok) begin
        busy     <= 1'b1;
        op_q     <= gfu_op_e'(op);
        addend_q <= opnd_b;
        mcand_q  <= {{W{1'b0}}, opnd_a};
        mplier_q <= opnd_c;
        acc_q    <= '0;
        busy_cnt <= '0;
      end else if (busy) begin
        acc_q    <= acc_nxt;
        mcand_q  <= mcand_nxt;
        mplier_q <= mplier_q >> 1;
        busy_cnt <= busy_cnt + 1'b1;
        if (finish) begin
          busy   <= 1'b0;
          done   <= 1'b1;
          result <= res_nxt;
        end
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R8
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy))); // R8
  AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (rst)
    busy |-> (busy_cnt < CW'(W))); // R8
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> ($stable(op_q) && $stable(addend_q))); // R9
  AST_MOD_STABLE: assert property (@(posedge clk) disable iff (rst)
    busy |-> $stable(mod_w)); // R10
  AST_GF_MASKED: assert property (@(posedge clk) disable iff (rst)
    (done && op_q == OP_GFMUL) |-> ((result & ~$past(fmask_w)) == '0)); // R2
endmodule

// File: tb/test_gf2m_clmul_unit.sv
`timescale 1ns/1ps
module test_gf2m_clmul_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [63:0] cfg_mod = '0;
  logic        start = 1'b0;
  logic [2:0]  op = '0;
  logic [63:0] opnd_a = '0, opnd_b = '0, opnd_c = '0;
  logic        busy, done;
  logic [63:0] result;
  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  gf2m_clmul_unit i_gf2m_clmul_unit (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_mod(cfg_mod), .start(start),
    .op(op), .opnd_a(opnd_a), .opnd_b(opnd_b), .opnd_c(opnd_c),
    .busy(busy), .done(done), .result(result)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic int msb_of(logic [63:0] v);
    int m = 0;
    for (int i = 0; i < 64; i++) if (v[i]) m = i;
    return m;
  endfunction

  function automatic int exp_lat(logic [63:0] c);
    return (c == 0) ? 1 : msb_of(c) + 1;
  endfunction

  function automatic logic [63:0] ref_gf(logic [63:0] md, logic [63:0] a, logic [63:0] c);
    logic [127:0] p1 = {64'd0, a};
    logic [63:0]  p = '0;
    logic [63:0]  mask = '0;
    int m = msb_of(md);
    for (int i = 0; i < 64; i++) begin
      if (c[i]) p = p ^ p1[63:0];
      p1 = p1 << 1;
      if (p1[m]) p1 = p1 ^ {64'd0, md};
    end
    for (int i = 0; i < 64; i++) mask[i] = (i < m);
    return p & mask;
  endfunction

  function automatic logic [127:0] ref_cl(logic [63:0] a, logic [63:0] c);
    logic [127:0] p = '0;
    for (int i = 0; i < 64; i++) if (c[i]) p = p ^ ({64'd0, a} << i);
    return p;
  endfunction

  task automatic cfg_write(logic [63:0] v);
    @(negedge clk); cfg_we = 1'b1; cfg_mod = v;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic run_op(input logic [2:0] o, input logic [63:0] a, b, c,
                        output logic [63:0] res, output int lat);
    @(negedge clk);
    op = o; opnd_a = a; opnd_b = b; opnd_c = c; start = 1'b1;
    @(posedge clk);
    @(negedge clk); start = 1'b0;
    lat = 0;
    do begin @(negedge clk); lat++; end while (!done && lat < 200);
    if (!done) chk("R8 watchdog on done", 64'd0, 64'd1);
    res = result;
  endtask

  task automatic t_reset();
    chk("R1 busy", {63'd0, busy}, 64'd0);
    chk("R1 done", {63'd0, done}, 64'd0);
    chk("R1 result", result, 64'd0);
  endtask

  task automatic t_gf_small();
    logic [63:0] r; int l;
    cfg_write(64'b1011);
    run_op(3'd0, 64'b111, 64'd0, 64'b101, r, l);
    chk("R2 gf3 product", r, 64'b110);
    chk("R8 latency c=5", 64'(l), 64'(exp_lat(64'b101)));
  endtask

  task automatic t_gf_wide();
    logic [63:0] r; int l;
    cfg_write(64'h11B);
    run_op(3'd0, 64'h80, 64'd0, 64'h83, r, l);
    chk("R2 gf8 product", r, 64'h01);
    run_op(3'd0, 64'h57, 64'd0, 64'h13, r, l);
    chk("R2 gf8 product b", r, ref_gf(64'h11B, 64'h57, 64'h13));
    cfg_write(64'h8000_0000_0000_001B);
    run_op(3'd0, 64'h1234_5678_9ABC_DEF0, 64'd0, 64'h4FED_CBA9_8765_4321, r, l);
    chk("R2 gf63 product", r, ref_gf(64'h8000_0000_0000_001B,
        64'h1234_5678_9ABC_DEF0, 64'h4FED_CBA9_8765_4321));
  endtask

  task automatic t_madd();
    logic [63:0] r; int l;
    cfg_write(64'h11B);
    run_op(3'd1, 64'h57, 64'hA5, 64'h83, r, l);
    chk("R3 fused", r, ref_gf(64'h11B, 64'h57, 64'h83) ^ 64'hA5);
  endtask

  task automatic t_clmul();
    logic [63:0] r; int l;
    logic [63:0] a, c;
    logic [127:0] p;
    a = 64'hDEAD_BEEF_0123_4567; c = 64'hF00D_CAFE_89AB_CDEF; p = ref_cl(a, c);
    run_op(3'd2, a, 64'hFFFF, c, r, l);
    chk("R4 clmul low", r, p[63:0]);
    chk("R8 latency c msb 63", 64'(l), 64'd64);
    run_op(3'd3, a, 64'd0, c, r, l);
    chk("R5 clmul high", r, p[127:64]);
    run_op(3'd4, a, 64'd0, c, r, l);
    chk("R6 clmul rev", r, p[126:63]);
    a = 64'hFFFF_FFFF_FFFF_FFFF; c = 64'h0000_0000_0000_8001; p = ref_cl(a, c);
    run_op(3'd3, a, 64'd0, c, r, l);
    chk("R5 clmul high ones", r, p[127:64]);
    run_op(3'd4, a, 64'd0, c, r, l);
    chk("R6 clmul rev ones", r, p[126:63]);
    run_op(3'd2, a, 64'd0, 64'd0, r, l);
    chk("R4 clmul by zero", r, 64'd0);
    chk("R8 latency c=0", 64'(l), 64'd1);
  endtask

  task automatic t_badop();
    logic [63:0] r; int l;
    run_op(3'd5, 64'h77, 64'h99, 64'h3, r, l);
    chk("R7 op5 zero", r, 64'd0);
    run_op(3'd7, 64'hFF, 64'h1, 64'h1, r, l);
    chk("R7 op7 zero", r, 64'd0);
  endtask

  task automatic t_overlap();
    logic [63:0] a, c; logic [127:0] p; int l; int extra;
    a = 64'h0F0F_1234_AAAA_5555; c = 64'h8000_0000_0000_0003; p = ref_cl(a, c);
    @(negedge clk);
    op = 3'd2; opnd_a = a; opnd_c = c; opnd_b = '0; start = 1'b1;
    @(posedge clk);
    @(negedge clk); start = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8 busy mid op", {63'd0, busy}, 64'd1);
    op = 3'd3; opnd_a = 64'h1; opnd_c = 64'h1; start = 1'b1;
    @(negedge clk); start = 1'b0;
    l = 4;
    while (!done && l < 200) begin @(negedge clk); l++; end
    chk("R9 first result kept", result, p[63:0]);
    chk("R9 latency kept", 64'(l), 64'd64);
    extra = 0;
    repeat (5) begin @(negedge clk); if (done || busy) extra++; end
    chk("R9 no second done", 64'(extra), 64'd0);
  endtask

  task automatic t_defer();
    logic [63:0] r; int l;
    cfg_write(64'h11B);
    @(negedge clk);
    op = 3'd0; opnd_a = 64'h80; opnd_c = 64'h83; start = 1'b1;
    @(posedge clk);
    @(negedge clk); start = 1'b0;
    cfg_we = 1'b1; cfg_mod = 64'b1011;
    @(negedge clk); cfg_we = 1'b0;
    l = 2;
    while (!done && l < 200) begin @(negedge clk); l++; end
    chk("R10 running op keeps old modulus", result, 64'h01);
    run_op(3'd0, 64'b111, 64'd0, 64'b101, r, l);
    chk("R10 next op uses new modulus", r, 64'b110);
    @(negedge clk);
    op = 3'd0; opnd_a = 64'h80; opnd_c = 64'h83; start = 1'b1;
    cfg_we = 1'b1; cfg_mod = 64'h11B;
    @(posedge clk);
    @(negedge clk); start = 1'b0; cfg_we = 1'b0;
    l = 1;
    while (!done && l < 200) begin @(negedge clk); l++; end
    chk("R10 write with start deferred", result, ref_gf(64'b1011, 64'h80, 64'h83));
    run_op(3'd0, 64'h80, 64'd0, 64'h83, r, l);
    chk("R10 write with start applied later", r, 64'h01);
  endtask

  task automatic t_degenerate();
    logic [63:0] r; int l;
    cfg_write(64'd1);
    run_op(3'd0, 64'hABCD, 64'd0, 64'h77, r, l);
    chk("R11 m0 product", r, 64'd0);
    run_op(3'd1, 64'hABCD, 64'h5A5A, 64'h77, r, l);
    chk("R11 m0 fused", r, 64'h5A5A);
    cfg_write(64'd0);
    run_op(3'd1, 64'h3, 64'h1234, 64'h3, r, l);
    chk("R11 zero modulus fused", r, 64'h1234);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_gf_small();
    t_gf_wide();
    t_madd();
    t_clmul();
    t_badop();
    t_overlap();
    t_defer();
    t_degenerate();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL R8 global watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule